// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address that a synchronous memory core uses during a short wrapping burst. A new burst starts when one of two active-low address strobes is seen while the three chip enables all stand active. One strobe belongs to the processor and the other to a cache controller. On a start the block captures the full address. The upper bits are then held for the whole burst, and the low bits feed a small wrapping beat counter. On later cycles with no strobe, an active-low step input moves the burst to its next beat, or holds it in place when high.

The order of the beats can be chosen while the block runs. In linear order the low bits count upward modulo four from the start value. In interleaved order the low bits are the start value XOR the beat number. The order input is sampled only at reset and when a burst starts, so changing it in the middle of a burst has no effect. The two strobes have a fixed priority. The processor strobe is gated by the first chip enable and the controller strobe is not. A strobe seen while the enables are inactive is a deselect cycle, and it ends the burst.

Top module: `burst_addr_seq`

## Requirements
- R1: At a rising edge where a strobe is recognised and the enables are active (sel_a_n low, sel_b high, sel_c_n low), word_addr shows addr_in from the next cycle and burst_valid is 1.
- R2: If both strobes are low at a start, start_src becomes 1 (processor). A start from the controller strobe alone sets start_src to 0.
- R3: While sel_a_n is high, the processor strobe is ignored. With the controller strobe high, the cycle acts as a strobe-free cycle, so it steps or holds according to step_n.
- R4: A recognised strobe while the enables are not all active clears burst_valid and leaves word_addr and start_src unchanged.
- R5: In linear order (order_xor low at the start), beat k has low bits equal to (start + k) mod 4.
- R6: In interleaved order (order_xor high at the start), beat k has low bits equal to start XOR k.
- R7: The burst counter wraps, so the fifth beat returns to the start address.
- R8: With no strobe recognised and step_n high, word_addr and burst_valid hold.
- R9: Bits 16 down to 2 of word_addr do not change while the burst steps.
- R10: order_xor is sampled only at reset and at a start; changing it mid-burst does not change the sequence.
- R11: Reset gives word_addr 0, burst_valid 0 and start_src 0.
- R12: step_n low with no burst active leaves word_addr unchanged and burst_valid 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | 17 | Address offered with a strobe |
| strb_cpu_n | input | 1 | Processor address strobe, active low, gated by sel_a_n |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Active-low advance to the next beat |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b | input | 1 | Chip enable, active high |
| sel_c_n | input | 1 | Chip enable, active low |
| order_xor | input | 1 | Burst order: 1 interleaved, 0 linear |
| word_addr | output | 17 | Current word address to the memory core |
| burst_valid | output | 1 | A burst is active |
| start_src | output | 1 | Strobe that began the burst: 1 processor, 0 controller |

## Verification
The bench walks full four-beat bursts in both orders and checks the fifth beat. A counter that saturated or failed to wrap would stop at the last beat instead of returning to the start. It flips the order input mid-burst. A design that read the input live would jump from the linear to the interleaved sequence on that beat. It drives both strobes together, the processor strobe with the first enable high, and a controller strobe with the enables off. Reversed priority, a missing enable gate, or a deselect that moved the address would show up as a wrong start_src, a spurious reload, or a changed word_addr.

// File: rtl/burst_addr_seq_pkg.sv
package burst_addr_seq_pkg;

   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_LOAD  = 2'd1,
      CYC_DESEL = 2'd2,
      CYC_STEP  = 2'd3
   } cyc_e;

   localparam logic SRC_CTL = 1'b0;
   localparam logic SRC_CPU = 1'b1;

   localparam int ORDER_RUNTIME = 0;
   localparam int ORDER_LINEAR  = 1;
   localparam int ORDER_XOR     = 2;

endpackage

// File: rtl/bas_strobe_decode.sv
module bas_strobe_decode
   import burst_addr_seq_pkg::*;
(
   input  logic strb_cpu_n,
   input  logic strb_ctl_n,
   input  logic step_n,
   input  logic sel_a_n,
   input  logic sel_b,
   input  logic sel_c_n,
   input  logic burst_on,
   output cyc_e cyc,
   output logic cpu_won
);
   logic cpu_hit;
   logic ctl_hit;
   logic seen;
   logic en_ok;

   always_comb begin
      cpu_hit = ~strb_cpu_n & ~sel_a_n;
      ctl_hit = ~strb_ctl_n;
      seen    = cpu_hit | ctl_hit;
      en_ok   = ~sel_a_n & sel_b & ~sel_c_n;
      cpu_won = cpu_hit;
      if (seen) begin
         cyc = en_ok ? CYC_LOAD : CYC_DESEL;
      end else if (~step_n && burst_on) begin
         cyc = CYC_STEP;
      end else begin
         cyc = CYC_IDLE;
      end
   end
endmodule

// File: rtl/bas_beat_counter.sv
module bas_beat_counter #(
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [BEAT_W-1:0] start_in,
   output logic [BEAT_W-1:0] start_q,
   output logic [BEAT_W-1:0] beat_q
);
   localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
         beat_q  <= '0;
      end else if (load) begin
         start_q <= start_in;
         beat_q  <= '0;
      end else if (step) begin
         beat_q  <= beat_q + ONE;
      end
   end
endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
   import burst_addr_seq_pkg::*;
#(
   parameter int BEAT_W     = 2,
   parameter int ORDER_MODE = ORDER_RUNTIME
) (
   input  logic [BEAT_W-1:0] start_q,
   input  logic [BEAT_W-1:0] beat_q,
   input  logic              use_xor,
   output logic [BEAT_W-1:0] low_bits
);
   logic [BEAT_W-1:0] lin_bits;
   logic [BEAT_W-1:0] xor_bits;

   assign lin_bits = start_q + beat_q;
   assign xor_bits = start_q ^ beat_q;

   generate
      if (ORDER_MODE == ORDER_LINEAR) begin : g_lin
         assign low_bits = lin_bits;
      end else if (ORDER_MODE == ORDER_XOR) begin : g_xor
         assign low_bits = xor_bits;
      end else begin : g_rt
         assign low_bits = use_xor ? xor_bits : lin_bits;
      end
   endgenerate

   logic unused_sel;
   assign unused_sel = use_xor;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_addr_seq_pkg::*;
#(
   parameter int ADDR_W     = 17,
   parameter int BEAT_W     = 2,
   parameter int ORDER_MODE = ORDER_RUNTIME
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              strb_cpu_n,
   input  logic              strb_ctl_n,
   input  logic              step_n,
   input  logic              sel_a_n,
   input  logic              sel_b,
   input  logic              sel_c_n,
   input  logic              order_xor,
   output logic [ADDR_W-1:0] word_addr,
   output logic              burst_valid,
   output logic              start_src
);
   localparam int UPPER_W = ADDR_W - BEAT_W;

   generate
      if (BEAT_W < 1 || ADDR_W <= BEAT_W) begin : g_bad_width
         $error("burst_addr_seq: ADDR_W must exceed BEAT_W and BEAT_W must be at least 1");
      end
      if (ORDER_MODE < ORDER_RUNTIME || ORDER_MODE > ORDER_XOR) begin : g_bad_mode
         $error("burst_addr_seq: ORDER_MODE out of range");
      end
   endgenerate

   cyc_e               cyc;
   logic               cpu_won;
   logic [UPPER_W-1:0] upper_q;
   logic               valid_q;
   logic               src_q;
   logic               order_q;
   logic [BEAT_W-1:0]  start_q;
   logic [BEAT_W-1:0]  beat_q;
   logic [BEAT_W-1:0]  low_bits;

   bas_strobe_decode u_dec (
      .strb_cpu_n (strb_cpu_n),
      .strb_ctl_n (strb_ctl_n),
      .step_n     (step_n),
      .sel_a_n    (sel_a_n),
      .sel_b      (sel_b),
      .sel_c_n    (sel_c_n),
      .burst_on   (valid_q),
      .cyc        (cyc),
      .cpu_won    (cpu_won)
   );

   bas_beat_counter #(.BEAT_W(BEAT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cyc == CYC_LOAD),
      .step     (cyc == CYC_STEP),
      .start_in (addr_in[BEAT_W-1:0]),
      .start_q  (start_q),
      .beat_q   (beat_q)
   );

   bas_order_map #(.BEAT_W(BEAT_W), .ORDER_MODE(ORDER_MODE)) u_map (
      .start_q  (start_q),
      .beat_q   (beat_q),
      .use_xor  (order_q),
      .low_bits (low_bits)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         upper_q <= '0;
         valid_q <= 1'b0;
         src_q   <= SRC_CTL;
         order_q <= order_xor;
      end else begin
         case (cyc)
            CYC_LOAD: begin
               upper_q <= addr_in[ADDR_W-1:BEAT_W];
               valid_q <= 1'b1;
               src_q   <= cpu_won ? SRC_CPU : SRC_CTL;
               order_q <= order_xor;
            end
            CYC_DESEL: valid_q <= 1'b0;
            default: ;
         endcase
      end
   end

   assign word_addr   = {upper_q, low_bits};
   assign burst_valid = valid_q;
   assign start_src   = src_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
   parameter int ADDR_W = 17,
   parameter int BEAT_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr_in,
   input logic              strb_cpu_n,
   input logic              strb_ctl_n,
   input logic              step_n,
   input logic              sel_a_n,
   input logic              sel_b,
   input logic              sel_c_n,
   input logic [ADDR_W-1:0] word_addr,
   input logic              burst_valid,
   input logic              start_src
);
   logic en_ok;
   logic seen;
   assign en_ok = ~sel_a_n & sel_b & ~sel_c_n;
   assign seen  = (~strb_cpu_n & ~sel_a_n) | ~strb_ctl_n;

   assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && en_ok) |=> (burst_valid && word_addr == $past(addr_in)));

   assert_cpu_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!strb_cpu_n && !strb_ctl_n && en_ok) |=> start_src);

   assert_ctl_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (strb_cpu_n && !strb_ctl_n && en_ok) |=> !start_src);

   assert_cpu_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!strb_cpu_n && sel_a_n && strb_ctl_n && step_n)
      |=> ($stable(word_addr) && $stable(burst_valid)));

   assert_desel_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && !en_ok) |=> (!burst_valid && $stable(word_addr) && $stable(start_src)));

   // R5 and R6: any step in either order moves the low bits
   assert_step_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!seen && !step_n && burst_valid) |=> (word_addr != $past(word_addr)));

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!seen && step_n) |=> ($stable(word_addr) && $stable(burst_valid)));

   assert_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!seen) |=> $stable(word_addr[ADDR_W-1:BEAT_W]));

   assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!seen && !burst_valid) |=> ($stable(word_addr) && !burst_valid));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .addr_in     (addr_in),
   .strb_cpu_n  (strb_cpu_n),
   .strb_ctl_n  (strb_ctl_n),
   .step_n      (step_n),
   .sel_a_n     (sel_a_n),
   .sel_b       (sel_b),
   .sel_c_n     (sel_c_n),
   .word_addr   (word_addr),
   .burst_valid (burst_valid),
   .start_src   (start_src)
);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;

   typedef struct packed {
      logic        cpu_n;
      logic        ctl_n;
      logic        stp_n;
      logic        a_n;
      logic        b;
      logic        c_n;
      logic        ox;
      logic [16:0] addr;
      logic [16:0] exp_addr;
      logic        exp_v;
      logic        exp_src;
      logic [3:0]  tag;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VT [NV] = '{
      '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,17'h12345,17'h12345,1'b1,1'b0,4'd1},  // R1 controller start, linear
      '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,17'h00000,17'h12346,1'b1,1'b0,4'd5},  // R5 beat 1
      '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,17'h00000,17'h12347,1'b1,1'b0,4'd5},  // R5 beat 2
      '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,17'h00000,17'h12344,1'b1,1'b0,4'd9},  // R9 upper bits kept on wrap of low bits
      '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,17'h00000,17'h12345,1'b1,1'b0,4'd7},  // R7 fifth beat
      '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,17'h00000,17'h12345,1'b1,1'b0,4'd8},  // R8 suspend
      '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,17'h00000,17'h12346,1'b1,1'b0,4'd10}, // R10 order flip ignored
      '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,17'h0ABCE,17'h0ABCE,1'b1,1'b1,4'd1},  // R1 processor start, interleaved
      '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,17'h00000,17'h0ABCF,1'b1,1'b1,4'd6},  // R6 10^01
      '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,17'h00000,17'h0ABCC,1'b1,1'b1,4'd6},  // R6 10^10
      '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,17'h00000,17'h0ABCD,1'b1,1'b1,4'd6},  // R6 10^11
      '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,17'h00000,17'h0ABCE,1'b1,1'b1,4'd7},  // R7 wrap interleaved
      '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,17'h1FFFF,17'h0ABCF,1'b1,1'b1,4'd3},  // R3 gated strobe steps
      '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,17'h1FFFF,17'h0ABCF,1'b1,1'b1,4'd3},  // R3 gated strobe holds
      '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,17'h1FFFF,17'h0ABCF,1'b0,1'b1,4'd4},  // R4 deselect
      '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,17'h00000,17'h0ABCF,1'b0,1'b1,4'd12}, // R12 step with no burst
      '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,17'h1F003,17'h1F003,1'b1,1'b1,4'd2},  // R2 both strobes
      '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,17'h00000,17'h1F000,1'b1,1'b1,4'd5},  // R5 11+1 wraps to 00
      '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,17'h00002,17'h00002,1'b1,1'b0,4'd2},  // R2 controller alone
      '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,17'h15555,17'h00002,1'b0,1'b0,4'd4}   // R4 gated cpu, ctl with enables off
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic [16:0] addr_in;
   logic        strb_cpu_n, strb_ctl_n, step_n, sel_a_n, sel_b, sel_c_n, order_xor;
   logic [16:0] word_addr;
   logic        burst_valid, start_src;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   burst_addr_seq dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr_in     (addr_in),
      .strb_cpu_n  (strb_cpu_n),
      .strb_ctl_n  (strb_ctl_n),
      .step_n      (step_n),
      .sel_a_n     (sel_a_n),
      .sel_b       (sel_b),
      .sel_c_n     (sel_c_n),
      .order_xor   (order_xor),
      .word_addr   (word_addr),
      .burst_valid (burst_valid),
      .start_src   (start_src)
   );

   task automatic check(input string what, input int tag, input logic [16:0] act, input logic [16:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic go_idle();
      strb_cpu_n = 1'b1; strb_ctl_n = 1'b1; step_n = 1'b1;
      sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
      order_xor = 1'b0; addr_in = '0;
   endtask

   initial begin
      rst_n = 1'b0;
      go_idle();
      repeat (3) @(negedge clk);
      // R11 reset state
      check("reset addr", 11, word_addr, 17'h0);
      check("reset valid", 11, {16'h0, burst_valid}, 17'h0);
      check("reset src", 11, {16'h0, start_src}, 17'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         strb_cpu_n = VT[i].cpu_n;
         strb_ctl_n = VT[i].ctl_n;
         step_n     = VT[i].stp_n;
         sel_a_n    = VT[i].a_n;
         sel_b      = VT[i].b;
         sel_c_n    = VT[i].c_n;
         order_xor  = VT[i].ox;
         addr_in    = VT[i].addr;
         @(posedge clk);
         @(negedge clk);
         check($sformatf("vec %0d addr", i), int'(VT[i].tag), word_addr, VT[i].exp_addr);
         check($sformatf("vec %0d valid", i), int'(VT[i].tag), {16'h0, burst_valid}, {16'h0, VT[i].exp_v});
         check($sformatf("vec %0d src", i), int'(VT[i].tag), {16'h0, start_src}, {16'h0, VT[i].exp_src});
      end

      // R11 reset in the middle of a burst
      go_idle();
      strb_cpu_n = 1'b0; addr_in = 17'h1ABCD;
      @(posedge clk); @(negedge clk);
      check("load before reset", 1, word_addr, 17'h1ABCD);
      go_idle();
      rst_n = 1'b0;
      @(posedge clk); @(negedge clk);
      check("mid-burst reset addr", 11, word_addr, 17'h0);
      check("mid-burst reset valid", 11, {16'h0, burst_valid}, 17'h0);
      check("mid-burst reset src", 11, {16'h0, start_src}, 17'h0);
      rst_n = 1'b1;

      // R10 order sampled at the start: interleaved start 01 then flip low
      order_xor = 1'b1; strb_ctl_n = 1'b0; addr_in = 17'h00001;
      @(posedge clk); @(negedge clk);
      strb_ctl_n = 1'b1; order_xor = 1'b0; step_n = 1'b0;
      @(posedge clk); @(negedge clk);
      check("xor beat1 after flip", 10, word_addr, 17'h00000);
      @(posedge clk); @(negedge clk);
      check("xor beat2 after flip", 10, word_addr, 17'h00003);
      go_idle();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule